// File: doc/BRIEF.md
# UART Control and Status Register Block

This block is the software-visible register front end of a simple serial port. A processor reaches it over a plain single-cycle read/write bus. Each access presents a word index and, for writes, a data word. The block holds these registers:

- four control registers, a FIFO-control register, baud modulator and baud count registers, and a one-millisecond register, which are plain storage;
- two status registers whose event bits are cleared by writing ones;
- a test register that reports the receive and transmit empty states;
- a one-character receive holding register, and a transmit data port that forwards a byte to an external serializer.

On the serializer side, received words arrive through a valid/ready handshake, and a separate break input reports a line break. The block has one registered interrupt output. It is the OR of two terms. The first is status register 1 masked by the enables in control register 1, which sit at the same bit positions. The second is status register 2 masked by enables taken from control registers 1 and 4. Software can return most of the block to its initial state by writing control register 2 with its active-low reset bit cleared.

The block is meant to sit between a bus bridge and a separate bit-level serializer. It holds no FIFO, does no baud generation and has no modem lines. The baud and FIFO registers only hold the values written to them.

Top module: `uart_ctrl_regs`

## Requirements
- R1: After `rst_n` the registers read as follows (word index: value). Control 1 (0x20): 0x0001. Control 2 (0x21): 0x0004. Control 3 (0x22): 0x0700. Control 4 (0x23): 0. FIFO control (0x24): 0. Status 1 (0x25): 0x6040. Status 2 (0x26): 0x4028. Baud modulator (0x2A): 0. Baud count (0x2B): 0x0004. Millisecond (0x2C): 0. Test (0x2D): 0x0060. Receive data (0x00): 0x4000. At the same time `irq` = 0 and `rx_ready` = 1.
- R2: `bus_rdata` is a combinational function of `bus_addr` and the current state. Writes to indices 0x20-0x24, 0x2A and 0x2C store only the low 16 data bits. Index 0x29 reads 0, and a write to it loads the baud count read at 0x2B. Writes to 0x2B, to the test register 0x2D and to any undefined index change nothing. Undefined indices read 0.
- R3: Writing control 2 with bit 0 = 0 is a software reset. Control 1 becomes 0, control 3 0x0700, the baud modulator 0 and the baud count 4. Status 1, status 2 and the receive buffer return to their R1 values. Control 2 stores the written value with bit 0 forced to 1. Control 4, FIFO control and the millisecond register keep their values.
- R4: `rx_ready` is high while status 1 bit 9 (receiver ready) is 0. A word taken with `rx_valid` in such a cycle is latched. It sets status 1 bit 9 and status 2 bit 0 (data ready) and clears test bit 5 (receive empty). While bit 9 is set, offered words are ignored.
- R5: A read of index 0x00 while the buffer is full returns the buffer with bit 15 set. It then clears status 1 bit 9 and status 2 bit 0 and sets test bit 5. A read while the buffer is empty returns the buffer with bit 15 clear and has no effect.
- R6: An accepted word with bit 11 (break flag) set also sets status 2 bit 2 (break detected).
- R7: A cycle with `brk_evt` high loads the buffer with 0x5800. It sets status 1 bit 9 and status 2 bits 0 and 2, whatever the buffer state. It takes precedence over a word offered in the same cycle.
- R8: A write to index 0x10 while control 2 bit 2 (transmit enable) is 1 drives `tx_valid` high for exactly the next cycle, with `tx_data` equal to the low 8 data bits. When that bit is 0 nothing is sent. In neither case does any status bit change.
- R9: A write to status 1 clears only bits set in 0x9DB0, and a write to status 2 clears only bits set in 0xBDD6. All other status bits ignore the write.
- R10: The interrupt condition holds when either of two terms is nonzero. The first is status 1 AND control 1 over bits 13 and 9. The second is status 2 AND a mask. That mask has bit 14 when control 1 bit 6 is set, plus control 4 bits 3 and 0.
- R11: `irq` is registered. It shows the condition for the register contents of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset into the boot state |
| bus_en | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word index of the register |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data for the presented index |
| tx_valid | output | 1 | One-cycle strobe carrying a byte to the serializer |
| tx_data | output | CHAR_W | Byte to transmit |
| rx_valid | input | 1 | Serializer offers a received word |
| rx_data | input | REG_W | Received word, bit 11 marks a break |
| rx_ready | output | 1 | Holding register can accept a word |
| brk_evt | input | 1 | Line break event |
| irq | output | 1 | Registered interrupt request |

## Verification
A wrong status or buffer bit appears on `bus_rdata` in the same cycle its index is presented. A wrong receiver-full flag also shows at once on `rx_ready`. A wrong enable or status bit reaches `irq` one clock later. A mistaken transmit decision shows on `tx_valid` in the cycle after the write. Because the bench compares every output against its model on every clock, an error can go unseen only until the next time the affected index is presented. Enough peeks are spread through the run to keep that window short.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;

   typedef enum logic [5:0] {
      RIX_RXD  = 6'h00,
      RIX_TXD  = 6'h10,
      RIX_CTL1 = 6'h20,
      RIX_CTL2 = 6'h21,
      RIX_CTL3 = 6'h22,
      RIX_CTL4 = 6'h23,
      RIX_FIFO = 6'h24,
      RIX_STS1 = 6'h25,
      RIX_STS2 = 6'h26,
      RIX_BINC = 6'h29,
      RIX_BMOD = 6'h2A,
      RIX_BCNT = 6'h2B,
      RIX_MSEC = 6'h2C,
      RIX_TEST = 6'h2D
   } reg_idx_e;

   localparam int IDX_BITS = 6;

   // bit positions that other logic decodes
   localparam int S1_RXRDY  = 9;
   localparam int S1_TXRDY  = 13;
   localparam int S2_DRDY   = 0;
   localparam int S2_BRKDET = 2;
   localparam int S2_TXDONE = 3;
   localparam int S2_TXEMP  = 14;
   localparam int C1_TXEIE  = 6;
   localparam int C2_RSTN   = 0;
   localparam int C2_TXON   = 2;
   localparam int C4_DONEIE = 3;
   localparam int C4_DRDYIE = 0;
   localparam int RW_BREAK  = 11;
   localparam int RW_FULL   = 15;
   localparam int T_RXEMP   = 5;
   localparam int T_TXEMP   = 6;

   localparam logic [15:0] STS1_INIT   = 16'h6040;
   localparam logic [15:0] STS2_INIT   = 16'h4028;
   localparam logic [15:0] STS1_W1C    = 16'h9DB0;
   localparam logic [15:0] STS2_W1C    = 16'hBDD6;
   localparam logic [15:0] RXBUF_INIT  = 16'h4000;
   localparam logic [15:0] RXBUF_BREAK = 16'h5800;
   localparam logic [15:0] CTL1_BOOT   = 16'h0001;
   localparam logic [15:0] CTL2_BOOT   = 16'h0004;
   localparam logic [15:0] CTL3_INIT   = 16'h0700;
   localparam logic [15:0] BCNT_INIT   = 16'h0004;

endpackage

// File: rtl/uart_sticky_reg.sv
module uart_sticky_reg #(
   parameter int             W        = 16,
   parameter logic [W-1:0]   RST_VAL  = '0,
   parameter logic [W-1:0]   CLR_MASK = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sreset,
   input  logic [W-1:0] hw_set,
   input  logic [W-1:0] hw_clr,
   input  logic         sw_clr_en,
   input  logic [W-1:0] sw_clr_data,
   output logic [W-1:0] q
);

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic bit_q;
      logic kept;
      assign kept = (bit_q & ~hw_clr[i]) | hw_set[i];
      if (CLR_MASK[i]) begin : g_w1c
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        bit_q <= RST_VAL[i];
            else if (sreset)   bit_q <= RST_VAL[i];
            else               bit_q <= kept & ~(sw_clr_en & sw_clr_data[i]);
         end
      end else begin : g_ro
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        bit_q <= RST_VAL[i];
            else if (sreset)   bit_q <= RST_VAL[i];
            else               bit_q <= kept;
         end
      end
      assign q[i] = bit_q;
   end

endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sreset,
   input  logic         brk,
   input  logic         load,
   input  logic [W-1:0] load_data,
   output logic [W-1:0] buf_q
);
   import uart_regs_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       buf_q <= W'(RXBUF_INIT);
      else if (sreset)  buf_q <= W'(RXBUF_INIT);
      else if (brk)     buf_q <= W'(RXBUF_BREAK);
      else if (load)    buf_q <= load_data;
   end

endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sts1,
   input  logic [W-1:0] sts2,
   input  logic [W-1:0] ctl1,
   input  logic [W-1:0] ctl4,
   output logic         irq
);
   import uart_regs_pkg::*;

   localparam logic [W-1:0] S1_SEL = W'((1 << S1_TXRDY) | (1 << S1_RXRDY));
   localparam logic [W-1:0] C4_SEL = W'((1 << C4_DONEIE) | (1 << C4_DRDYIE));

   logic [W-1:0] s2_mask;
   logic         want;

   always_comb begin
      s2_mask = ctl4 & C4_SEL;
      if (ctl1[C1_TXEIE]) s2_mask[S2_TXEMP] = 1'b1;
      want = (|(sts1 & ctl1 & S1_SEL)) | (|(sts2 & s2_mask));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= want;
   end

endmodule

// File: rtl/uart_ctrl_regs.sv
module uart_ctrl_regs
   import uart_regs_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int BUS_W  = 32,
   parameter int REG_W  = 16,
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              tx_valid,
   output logic [CHAR_W-1:0] tx_data,
   input  logic              rx_valid,
   input  logic [REG_W-1:0]  rx_data,
   output logic              rx_ready,
   input  logic              brk_evt,
   output logic              irq
);

   if (REG_W < 16)     begin : g_chk_reg  $error("REG_W must be at least 16"); end
   if (BUS_W < REG_W)  begin : g_chk_bus  $error("BUS_W must cover REG_W"); end
   if (CHAR_W > REG_W) begin : g_chk_char $error("CHAR_W must fit in REG_W"); end
   if (ADDR_W < IDX_BITS) begin : g_chk_addr $error("ADDR_W too small"); end

   localparam logic [REG_W-1:0] ONE = REG_W'(1);

   logic upper_ok;
   if (ADDR_W > IDX_BITS) begin : g_wide
      assign upper_ok = (bus_addr[ADDR_W-1:IDX_BITS] == '0);
   end else begin : g_exact
      assign upper_ok = 1'b1;
   end

   if (BUS_W > REG_W) begin : g_hi
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^bus_wdata[BUS_W-1:REG_W];
   end

   reg_idx_e         idx;
   logic             wr, rd, sreset, rx_full, rx_load, rd_take;
   logic [REG_W-1:0] wlow;
   logic [REG_W-1:0] ctl1_q, ctl2_q, ctl3_q, ctl4_q, fifo_q, bmod_q, bcnt_q, msec_q;
   logic [REG_W-1:0] sts1_q, sts2_q, rxbuf_q;
   logic [REG_W-1:0] s1_set, s1_clr, s2_set, s2_clr, test_v;

   assign idx     = reg_idx_e'(bus_addr[IDX_BITS-1:0]);
   assign wr      = bus_en & bus_we & upper_ok;
   assign rd      = bus_en & ~bus_we & upper_ok;
   assign wlow    = bus_wdata[REG_W-1:0];
   assign sreset  = wr && (idx == RIX_CTL2) && !bus_wdata[C2_RSTN];
   assign rx_full = sts1_q[S1_RXRDY];
   assign rx_ready = ~rx_full;
   assign rx_load = rx_valid & ~rx_full & ~brk_evt;
   assign rd_take = rd && (idx == RIX_RXD) && rx_full;

   always_comb begin
      s1_set = '0;
      s2_set = '0;
      s1_clr = '0;
      s2_clr = '0;
      if (rx_load || brk_evt) begin
         s1_set[S1_RXRDY] = 1'b1;
         s2_set[S2_DRDY]  = 1'b1;
      end
      if (brk_evt || (rx_load && rx_data[RW_BREAK])) s2_set[S2_BRKDET] = 1'b1;
      if (rd_take) begin
         s1_clr[S1_RXRDY] = 1'b1;
         s2_clr[S2_DRDY]  = 1'b1;
      end
   end

   uart_sticky_reg #(.W(REG_W), .RST_VAL(REG_W'(STS1_INIT)), .CLR_MASK(REG_W'(STS1_W1C))) u_sts1 (
      .clk(clk), .rst_n(rst_n), .sreset(sreset), .hw_set(s1_set), .hw_clr(s1_clr),
      .sw_clr_en(wr && (idx == RIX_STS1)), .sw_clr_data(wlow), .q(sts1_q));

   uart_sticky_reg #(.W(REG_W), .RST_VAL(REG_W'(STS2_INIT)), .CLR_MASK(REG_W'(STS2_W1C))) u_sts2 (
      .clk(clk), .rst_n(rst_n), .sreset(sreset), .hw_set(s2_set), .hw_clr(s2_clr),
      .sw_clr_en(wr && (idx == RIX_STS2)), .sw_clr_data(wlow), .q(sts2_q));

   uart_rx_hold #(.W(REG_W)) u_rxbuf (
      .clk(clk), .rst_n(rst_n), .sreset(sreset), .brk(brk_evt),
      .load(rx_load), .load_data(rx_data), .buf_q(rxbuf_q));

   uart_irq_gen #(.W(REG_W)) u_irq (
      .clk(clk), .rst_n(rst_n), .sts1(sts1_q), .sts2(sts2_q),
      .ctl1(ctl1_q), .ctl4(ctl4_q), .irq(irq));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl1_q <= REG_W'(CTL1_BOOT);
         ctl2_q <= REG_W'(CTL2_BOOT);
         ctl3_q <= REG_W'(CTL3_INIT);
         ctl4_q <= '0;
         fifo_q <= '0;
         bmod_q <= '0;
         bcnt_q <= REG_W'(BCNT_INIT);
         msec_q <= '0;
      end else if (sreset) begin
         ctl1_q <= '0;
         ctl2_q <= wlow | ONE;
         ctl3_q <= REG_W'(CTL3_INIT);
         bmod_q <= '0;
         bcnt_q <= REG_W'(BCNT_INIT);
      end else if (wr) begin
         case (idx)
            RIX_CTL1: ctl1_q <= wlow;
            RIX_CTL2: ctl2_q <= wlow;
            RIX_CTL3: ctl3_q <= wlow;
            RIX_CTL4: ctl4_q <= wlow;
            RIX_FIFO: fifo_q <= wlow;
            RIX_BINC: bcnt_q <= wlow;
            RIX_BMOD: bmod_q <= wlow;
            RIX_MSEC: msec_q <= wlow;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_valid <= 1'b0;
         tx_data  <= '0;
      end else begin
         tx_valid <= 1'b0;
         if (wr && (idx == RIX_TXD) && ctl2_q[C2_TXON]) begin
            tx_valid <= 1'b1;
            tx_data  <= bus_wdata[CHAR_W-1:0];
         end
      end
   end

   always_comb begin
      test_v = '0;
      test_v[T_TXEMP] = 1'b1;
      test_v[T_RXEMP] = ~rx_full;
      bus_rdata = '0;
      if (upper_ok) begin
         case (idx)
            RIX_RXD: begin
               bus_rdata = BUS_W'(rxbuf_q);
               bus_rdata[RW_FULL] = rxbuf_q[RW_FULL] | rx_full;
            end
            RIX_CTL1: bus_rdata = BUS_W'(ctl1_q);
            RIX_CTL2: bus_rdata = BUS_W'(ctl2_q);
            RIX_CTL3: bus_rdata = BUS_W'(ctl3_q);
            RIX_CTL4: bus_rdata = BUS_W'(ctl4_q);
            RIX_FIFO: bus_rdata = BUS_W'(fifo_q);
            RIX_STS1: bus_rdata = BUS_W'(sts1_q);
            RIX_STS2: bus_rdata = BUS_W'(sts2_q);
            RIX_BMOD: bus_rdata = BUS_W'(bmod_q);
            RIX_BCNT: bus_rdata = BUS_W'(bcnt_q);
            RIX_MSEC: bus_rdata = BUS_W'(msec_q);
            RIX_TEST: bus_rdata = BUS_W'(test_v);
            default:  bus_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/uart_ctrl_regs_chk.sv
module uart_ctrl_regs_chk #(
   parameter int ADDR_W = 6,
   parameter int BUS_W  = 32,
   parameter int REG_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_en,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [BUS_W-1:0]  bus_wdata,
   input logic              rx_valid,
   input logic              rx_ready,
   input logic              brk_evt,
   input logic              tx_valid,
   input logic              irq,
   input logic [REG_W-1:0]  ctl1_q,
   input logic [REG_W-1:0]  ctl2_q,
   input logic [REG_W-1:0]  ctl4_q,
   input logic [REG_W-1:0]  sts1_q,
   input logic [REG_W-1:0]  sts2_q
);

   logic srst_w, sts2_w, txd_w, rxd_r;
   assign srst_w = bus_en && bus_we && (bus_addr == ADDR_W'(6'h21)) && !bus_wdata[0];
   assign sts2_w = bus_en && bus_we && (bus_addr == ADDR_W'(6'h26));
   assign txd_w  = bus_en && bus_we && (bus_addr == ADDR_W'(6'h10));
   assign rxd_r  = bus_en && !bus_we && (bus_addr == '0);

   // R3
   srst_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      srst_w |=> (ctl1_q == '0) && ctl2_q[0]);

   // R4
   rx_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_ready && !srst_w) |=> !rx_ready);

   // R4
   rdy_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sts1_q[9] == sts2_q[0]);

   // R5
   rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rxd_r && !rx_ready && !brk_evt) |=> rx_ready);

   // R7
   brk_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_evt && !srst_w && !(sts2_w && bus_wdata[2])) |=> sts2_q[2] && !rx_ready);

   // R8
   tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> $past(txd_w && ctl2_q[2]));

   // R10
   irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((sts1_q & ctl1_q & REG_W'(16'h2200)) != '0) |=> irq);

   // R10
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl1_q[13] && !ctl1_q[9] && !ctl1_q[6] && !ctl4_q[3] && !ctl4_q[0]) |=> !irq);

endmodule

bind uart_ctrl_regs uart_ctrl_regs_chk #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .REG_W(REG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .rx_valid(rx_valid), .rx_ready(rx_ready), .brk_evt(brk_evt),
   .tx_valid(tx_valid), .irq(irq), .ctl1_q(ctl1_q), .ctl2_q(ctl2_q), .ctl4_q(ctl4_q),
   .sts1_q(sts1_q), .sts2_q(sts2_q));

// File: tb/uart_ctrl_regs_tb.sv
`timescale 1ns/1ps
module uart_ctrl_regs_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0, bus_we = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        tx_valid;
   logic [7:0]  tx_data;
   logic        rx_valid = 1'b0;
   logic [15:0] rx_data = '0;
   logic        rx_ready;
   logic        brk_evt = 1'b0;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   string cur_tag = "R1";

   always #2 clk = ~clk;

   uart_ctrl_regs u_dut (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready), .brk_evt(brk_evt), .irq(irq));

   // behavioural reference model
   logic [15:0] m_c1, m_c2, m_c3, m_c4, m_fifo, m_bmod, m_bcnt, m_ms, m_s1, m_s2, m_buf;
   logic        m_irq, m_txv;
   logic [7:0]  m_txd;

   task automatic soft_state();
      m_c1 = 16'h0; m_c3 = 16'h0700; m_bmod = 16'h0; m_bcnt = 16'h0004;
      m_s1 = 16'h6040; m_s2 = 16'h4028; m_buf = 16'h4000;
   endtask

   function automatic logic [31:0] exp_rd(input logic [5:0] a);
      logic full;
      full = m_s1[9];
      case (a)
         6'h00: exp_rd = {16'h0, m_buf | (full ? 16'h8000 : 16'h0)};
         6'h20: exp_rd = {16'h0, m_c1};
         6'h21: exp_rd = {16'h0, m_c2};
         6'h22: exp_rd = {16'h0, m_c3};
         6'h23: exp_rd = {16'h0, m_c4};
         6'h24: exp_rd = {16'h0, m_fifo};
         6'h25: exp_rd = {16'h0, m_s1};
         6'h26: exp_rd = {16'h0, m_s2};
         6'h2A: exp_rd = {16'h0, m_bmod};
         6'h2B: exp_rd = {16'h0, m_bcnt};
         6'h2C: exp_rd = {16'h0, m_ms};
         6'h2D: exp_rd = full ? 32'h40 : 32'h60;
         default: exp_rd = 32'h0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         soft_state();
         m_c1 = 16'h0001; m_c2 = 16'h0004; m_c4 = 16'h0; m_fifo = 16'h0; m_ms = 16'h0;
         m_irq = 1'b0; m_txv = 1'b0; m_txd = 8'h0;
      end else begin : step
         logic irq_n, fo;
         logic [15:0] w;
         w = bus_wdata[15:0];
         irq_n = ((m_s1 & m_c1 & 16'h2200) != 0) ||
                 ((m_s2 & ((m_c1[6] ? 16'h4000 : 16'h0) | (m_c4 & 16'h0009))) != 0);
         fo = m_s1[9];
         m_txv = 1'b0;
         if (bus_en && !bus_we && bus_addr == 6'h00 && fo) begin
            m_s1[9] = 1'b0; m_s2[0] = 1'b0;
         end
         if (brk_evt) begin
            m_buf = 16'h5800; m_s1[9] = 1'b1; m_s2[0] = 1'b1; m_s2[2] = 1'b1;
         end else if (rx_valid && !fo) begin
            m_buf = rx_data; m_s1[9] = 1'b1; m_s2[0] = 1'b1;
            if (rx_data[11]) m_s2[2] = 1'b1;
         end
         if (bus_en && bus_we) begin
            case (bus_addr)
               6'h10: if (m_c2[2]) begin m_txv = 1'b1; m_txd = bus_wdata[7:0]; end
               6'h20: m_c1 = w;
               6'h21: begin
                  if (!w[0]) soft_state();
                  m_c2 = w | 16'h1;
               end
               6'h22: m_c3 = w;
               6'h23: m_c4 = w;
               6'h24: m_fifo = w;
               6'h25: m_s1 = m_s1 & ~(w & 16'h9DB0);
               6'h26: m_s2 = m_s2 & ~(w & 16'hBDD6);
               6'h29: m_bcnt = w;
               6'h2A: m_bmod = w;
               6'h2C: m_ms = w;
               default: ;
            endcase
         end
         m_irq = irq_n;
      end
   end

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag,
                      input string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // per-clock comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(bus_rdata, exp_rd(bus_addr), cur_tag, "rdata vs model");
         chk({31'h0, irq}, {31'h0, m_irq}, cur_tag, "irq vs model");
         chk({31'h0, rx_ready}, {31'h0, ~m_s1[9]}, cur_tag, "rx_ready vs model");
         chk({31'h0, tx_valid}, {31'h0, m_txv}, cur_tag, "tx_valid vs model");
         if (m_txv) chk({24'h0, tx_data}, {24'h0, m_txd}, cur_tag, "tx_data vs model");
      end
   end

   task automatic step1();
      @(posedge clk); #1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step1();
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      step1();
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic peek(input logic [5:0] a, input logic [31:0] e, input string tag);
      bus_addr = a;
      @(negedge clk);
      chk(bus_rdata, e, tag, $sformatf("read idx %h", a));
      step1();
   endtask

   task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      chk(bus_rdata, e, tag, $sformatf("bus read idx %h", a));
      step1();
      bus_en = 1'b0;
   endtask

   task automatic rx_push(input logic [15:0] d);
      rx_valid = 1'b1; rx_data = d;
      step1();
      rx_valid = 1'b0;
   endtask

   task automatic pin(input logic act, input logic e, input string tag, input string what);
      chk({31'h0, act}, {31'h0, e}, tag, what);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      step1();

      // R1 boot values
      cur_tag = "R1";
      peek(6'h20, 32'h0001, "R1"); peek(6'h21, 32'h0004, "R1");
      peek(6'h22, 32'h0700, "R1"); peek(6'h23, 32'h0000, "R1");
      peek(6'h24, 32'h0000, "R1"); peek(6'h25, 32'h6040, "R1");
      peek(6'h26, 32'h4028, "R1"); peek(6'h2A, 32'h0000, "R1");
      peek(6'h2B, 32'h0004, "R1"); peek(6'h2C, 32'h0000, "R1");
      peek(6'h2D, 32'h0060, "R1"); peek(6'h00, 32'h4000, "R1");
      pin(irq, 1'b0, "R1", "irq"); pin(rx_ready, 1'b1, "R1", "rx_ready");

      // R2 decode, 16-bit storage, aliases, ignored writes
      cur_tag = "R2";
      wr(6'h22, 32'hDEAD_BEEF); peek(6'h22, 32'hBEEF, "R2");
      wr(6'h24, 32'h1234_5678); peek(6'h24, 32'h5678, "R2");
      wr(6'h2C, 32'hFFFF_0321); peek(6'h2C, 32'h0321, "R2");
      wr(6'h2A, 32'h0000_0055); peek(6'h2A, 32'h0055, "R2");
      wr(6'h29, 32'h00AB_CD10); peek(6'h2B, 32'hCD10, "R2"); peek(6'h29, 32'h0, "R2");
      wr(6'h2B, 32'h0000_9999); peek(6'h2B, 32'hCD10, "R2");
      wr(6'h2D, 32'h0000_FFFF); peek(6'h2D, 32'h0060, "R2");
      wr(6'h30, 32'h0000_1234); peek(6'h30, 32'h0, "R2"); peek(6'h10, 32'h0, "R2");

      // R4 / R5 receive path
      cur_tag = "R4";
      rx_push(16'h0041);
      pin(rx_ready, 1'b0, "R4", "rx_ready after accept");
      peek(6'h25, 32'h6240, "R4"); peek(6'h26, 32'h4029, "R4"); peek(6'h2D, 32'h0040, "R4");
      rx_push(16'h0062);
      peek(6'h00, 32'h8041, "R4");
      cur_tag = "R5";
      rd(6'h00, 32'h8041, "R5");
      peek(6'h25, 32'h6040, "R5"); peek(6'h26, 32'h4028, "R5"); peek(6'h2D, 32'h0060, "R5");
      rd(6'h00, 32'h0041, "R5");
      pin(rx_ready, 1'b1, "R5", "rx_ready after empty read");

      // R6 break flag in word, R9 write-one-to-clear
      cur_tag = "R6";
      rx_push(16'h0841);
      peek(6'h26, 32'h402D, "R6");
      cur_tag = "R9";
      wr(6'h25, 32'h0000_FFFF); peek(6'h25, 32'h6240, "R9");
      wr(6'h26, 32'h0000_FFFF); peek(6'h26, 32'h4029, "R9");
      rd(6'h00, 32'h8841, "R9");

      // R7 break event beats a word offered in the same cycle
      cur_tag = "R7";
      brk_evt = 1'b1; rx_valid = 1'b1; rx_data = 16'h0033;
      step1();
      brk_evt = 1'b0; rx_valid = 1'b0;
      peek(6'h00, 32'hD800, "R7"); peek(6'h26, 32'h402D, "R7");
      brk_evt = 1'b1; step1(); brk_evt = 1'b0;
      peek(6'h00, 32'hD800, "R7");
      rd(6'h00, 32'hD800, "R7");
      wr(6'h26, 32'h0000_0004); peek(6'h26, 32'h4028, "R7");

      // R8 transmit port
      cur_tag = "R8";
      wr(6'h10, 32'h0000_01A5);
      pin(tx_valid, 1'b1, "R8", "tx_valid with enable");
      chk({24'h0, tx_data}, 32'hA5, "R8", "tx_data");
      step1();
      pin(tx_valid, 1'b0, "R8", "tx_valid single cycle");
      wr(6'h21, 32'h0000_0001);
      wr(6'h10, 32'h0000_005A);
      pin(tx_valid, 1'b0, "R8", "tx_valid without enable");
      peek(6'h25, 32'h6040, "R8"); peek(6'h26, 32'h4028, "R8");
      wr(6'h21, 32'h0000_0005);

      // R10 / R11 interrupt
      cur_tag = "R11";
      wr(6'h20, 32'h0000_2001);
      pin(irq, 1'b0, "R11", "irq one cycle late");
      step1();
      pin(irq, 1'b1, "R11", "irq after latency");
      cur_tag = "R10";
      wr(6'h20, 32'h0000_0001); idle(1); pin(irq, 1'b0, "R10", "irq masked");
      wr(6'h23, 32'h0000_0008); idle(1); pin(irq, 1'b1, "R10", "tx done enable");
      wr(6'h23, 32'h0000_0001); idle(1); pin(irq, 1'b0, "R10", "drdy enable, empty");
      rx_push(16'h0011); idle(1); pin(irq, 1'b1, "R10", "drdy enable, full");
      rd(6'h00, 32'h8011, "R10"); idle(1); pin(irq, 1'b0, "R10", "after read");
      wr(6'h23, 32'h0); wr(6'h20, 32'h0000_0041); idle(1);
      pin(irq, 1'b1, "R10", "tx empty enable");
      wr(6'h20, 32'h0000_0201); idle(1); pin(irq, 1'b0, "R10", "rrdy enable, empty");
      rx_push(16'h0022); idle(1); pin(irq, 1'b1, "R10", "rrdy enable, full");

      // R3 software reset
      cur_tag = "R3";
      wr(6'h23, 32'h0000_0008);
      wr(6'h21, 32'h0000_0006);
      peek(6'h21, 32'h0007, "R3"); peek(6'h20, 32'h0000, "R3");
      peek(6'h22, 32'h0700, "R3"); peek(6'h2A, 32'h0000, "R3");
      peek(6'h2B, 32'h0004, "R3"); peek(6'h23, 32'h0008, "R3");
      peek(6'h24, 32'h5678, "R3"); peek(6'h2C, 32'h0321, "R3");
      peek(6'h25, 32'h6040, "R3"); peek(6'h26, 32'h4028, "R3");
      peek(6'h2D, 32'h0060, "R3"); peek(6'h00, 32'h4000, "R3");
      pin(rx_ready, 1'b1, "R3", "rx_ready after soft reset");
      idle(2);
      pin(irq, 1'b1, "R3", "control 4 kept enables irq");

      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog (all requirements): actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule